// File: doc/BRIEF.md
# ADC Monitor Register Front End

This block is the control and status face of an ADC monitoring peripheral. Software reaches it over a plain register bus: address, write strobe, write data, read strobe and registered read data. Through that bus it can issue a keyed soft reset, gate and enable interrupts, inspect and toggle interrupt status, poll a status word that clears when read, request conversions and read back one result word per converter channel.

On the converter side the block takes single-cycle end-of-conversion and end-of-sequence pulses, together with the channel index and the result data that come with each conversion. It drives a conversion-start request, a converter reset and one level interrupt. The start request is the OR of a software-held bit and an external pin, which is synchronized before use. The converter itself is only stimulus.

The bus and converter pins are plain control signals. There is no valid/ready handshake: a strobe acts in the cycle it is high, and the converter pulses are never stalled.

Top module: `adcmon_regif`

## Requirements
- R1: A write of exactly 0x0000_000A to the reset register (offset 0x000) holds `conv_reset` high for exactly 16 cycles, starting the cycle after the write edge. A write of any other value leaves `conv_reset` low and leaves every register unchanged.
- R2: During a soft reset, every other register (status, start, global enable, interrupt enable, interrupt status, results) is cleared to zero, and every bus read returns 0.
- R3: Bit 31 of the global enable register (offset 0x010) gates `irq`. While that bit is 0, `irq` stays 0.
- R4: The interrupt enable register (offset 0x018) holds bits 7:0. `irq` is a register equal to global enable AND the OR over bits 7:0 of (status AND enable), and it follows an interrupt status change one cycle later.
- R5: A write to the interrupt status register (offset 0x014) toggles each of bits 7:0 that is written as 1. Writing back a value just read therefore returns the register to zero.
- R6: An end-of-conversion pulse sets interrupt status bit 0 and an end-of-sequence pulse sets bit 1. A hardware set in the same cycle as a toggle of that bit leaves the bit at 1.
- R7: Status register (offset 0x004) bit 0 is a sticky end-of-conversion flag and bit 1 is a sticky end-of-sequence flag. A read returns the current flags and then clears them. A flag set in the same cycle as the read stays at 1.
- R8: `conv_start` is the OR of start register (offset 0x008) bit 0 and a copy of `ext_start` passed through two flops. A pin change therefore appears after the second clock edge.
- R9: On an end-of-conversion pulse, `conv_data` is stored for channel `conv_chan`. It reads back zero-extended at offset 0x200 + 4 × channel, so channel 3 is at 0x20C.
- R10: Read data is registered and appears the cycle after `bus_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| conv_eoc | input | 1 | End-of-conversion pulse |
| conv_eos | input | 1 | End-of-sequence pulse |
| conv_chan | input | 5 | Channel of the finished conversion |
| conv_data | input | 16 | Result of the finished conversion |
| ext_start | input | 1 | External conversion-start pin (asynchronous) |
| conv_start | output | 1 | Conversion-start request |
| conv_reset | output | 1 | Converter reset during a soft reset |
| irq | output | 1 | Interrupt |

## Verification
Two collisions matter for this block. The first is a software toggle of an interrupt status bit in the same cycle as the hardware set of that bit. The second is a read of the status register in the same cycle as an end-of-conversion pulse. The bench provokes both by driving the bus strobe and the converter pulse on the same clock edge. In each case it requires the bit to end at 1: it reads the register back, and for the status collision it also checks that the colliding read returned the value from before the pulse.

// File: rtl/adcmon_pkg.sv
package adcmon_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_SWRST  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_START  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_GIE    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_ISR    = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_IER    = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_RESULT = 12'h200;
  localparam logic [DATA_W-1:0] RESET_KEY  = 32'h0000_000A;
  localparam int ISR_EOC_BIT = 0;
  localparam int ISR_EOS_BIT = 1;
endpackage

// File: rtl/adcmon_swreset.sv
module adcmon_swreset #(
  parameter int          HOLD = 16,
  parameter logic [31:0] KEY  = 32'h0000_000A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  output logic        sreset
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt <= '0;
    else if (cnt != '0)                   cnt <= cnt - 1'b1;
    else if (key_wr && key_data == KEY)   cnt <= CW'(HOLD);
  end

  assign sreset = (cnt != '0);

  // R1: a keyed write from idle starts the hold
  a_r1_key_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == KEY && !sreset) |=> sreset);
  // R1: a wrong key from idle starts nothing
  a_r1_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != KEY && !sreset) |=> !sreset);
  // R1: the hold never ends early
  a_r1_hold_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CW'(1)) |=> sreset);
endmodule

// File: rtl/adcmon_irq.sv
module adcmon_irq #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            gie_wr,
  input  logic            ier_wr,
  input  logic            isr_wr,
  input  logic [31:0]     wdata,
  input  logic [NIRQ-1:0] hw_set,
  output logic            gie,
  output logic [NIRQ-1:0] ier,
  output logic [NIRQ-1:0] isr,
  output logic            irq
);
  logic [NIRQ-1:0] toggle;
  assign toggle = isr_wr ? wdata[NIRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0; ier <= '0; isr <= '0; irq <= 1'b0;
    end else if (clr) begin
      gie <= 1'b0; ier <= '0; isr <= '0; irq <= 1'b0;
    end else begin
      if (gie_wr) gie <= wdata[31];
      if (ier_wr) ier <= wdata[NIRQ-1:0];
      isr <= (isr ^ toggle) | hw_set;
      irq <= gie & (|(isr & ier));
    end
  end

  // R3: with global enable off, the line stays low next cycle
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq);
  // R6: hardware set wins over a toggle
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hw_set[0]) |=> isr[0]);
  // R5: without hardware sets, a toggle flips exactly the written bits
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && isr_wr && hw_set == '0) |=> (isr == ($past(isr) ^ $past(wdata[NIRQ-1:0]))));
endmodule

// File: rtl/adcmon_start_sync.sv
module adcmon_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start_wr,
  input  logic start_bit,
  input  logic ext_start,
  output logic start_reg,
  output logic conv_start
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_reg <= 1'b0;
    else if (clr)      start_reg <= 1'b0;
    else if (start_wr) start_reg <= start_bit;
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= (s == 0) ? ext_start : sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign conv_start = start_reg | sync_q[STAGES-1];

  // R8: the software bit alone is enough to request a conversion
  a_r8_reg_requests: assert property (@(posedge clk) disable iff (!rst_n)
    start_reg |-> conv_start);
endmodule

// File: rtl/adcmon_results.sv
module adcmon_results #(
  parameter int NCHAN = 32,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(NCHAN)-1:0] wchan,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NCHAN)-1:0] rchan,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] bank [NCHAN];

  generate
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   bank[c] <= '0;
        else if (clr)                 bank[c] <= '0;
        else if (we && wchan == c)    bank[c] <= wdata;
      end
    end
  endgenerate

  assign rdata = bank[rchan];

  // R9: a stored result reads back on the next cycle when addressed
  a_r9_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && we && rchan == wchan) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/adcmon_regif.sv
module adcmon_regif
  import adcmon_pkg::*;
#(
  parameter int NCHAN = 32,
  parameter int RES_W = 16,
  parameter int NIRQ  = 8,
  parameter int HOLD  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        conv_eoc,
  input  logic        conv_eos,
  input  logic [4:0]  conv_chan,
  input  logic [15:0] conv_data,
  input  logic        ext_start,
  output logic        conv_start,
  output logic        conv_reset,
  output logic        irq
);
  localparam int CW      = $clog2(NCHAN);
  localparam int RES_SPAN = NCHAN * 4;

  logic sreset;
  logic wr_ok, rd_ok;
  logic gie;
  logic [NIRQ-1:0] ier, isr, hw_set;
  logic start_reg;
  logic [1:0] status;
  logic [RES_W-1:0] res_rd;
  logic [11:0] res_ofs;
  logic res_hit;
  logic [31:0] rd_mux;

  assign wr_ok = bus_wr & ~sreset;
  assign rd_ok = bus_rd & ~sreset;

  adcmon_swreset #(.HOLD(HOLD), .KEY(RESET_KEY)) u_rst (
    .clk(clk), .rst_n(rst_n),
    .key_wr(bus_wr && bus_addr == OFS_SWRST), .key_data(bus_wdata),
    .sreset(sreset));
  assign conv_reset = sreset;

  always_comb begin
    hw_set = '0;
    hw_set[ISR_EOC_BIT] = conv_eoc;
    hw_set[ISR_EOS_BIT] = conv_eos;
  end

  adcmon_irq #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(sreset),
    .gie_wr(wr_ok && bus_addr == OFS_GIE),
    .ier_wr(wr_ok && bus_addr == OFS_IER),
    .isr_wr(wr_ok && bus_addr == OFS_ISR),
    .wdata(bus_wdata), .hw_set(hw_set),
    .gie(gie), .ier(ier), .isr(isr), .irq(irq));

  adcmon_start_sync #(.STAGES(2)) u_start (
    .clk(clk), .rst_n(rst_n), .clr(sreset),
    .start_wr(wr_ok && bus_addr == OFS_START), .start_bit(bus_wdata[0]),
    .ext_start(ext_start), .start_reg(start_reg), .conv_start(conv_start));

  assign res_ofs = bus_addr - OFS_RESULT;
  assign res_hit = (bus_addr >= OFS_RESULT) && (res_ofs < 12'(RES_SPAN)) && (bus_addr[1:0] == 2'b00);

  adcmon_results #(.NCHAN(NCHAN), .DW(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(sreset),
    .we(conv_eoc), .wchan(conv_chan[CW-1:0]), .wdata(conv_data[RES_W-1:0]),
    .rchan(res_ofs[2 +: CW]), .rdata(res_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= '0;
    else if (sreset) status <= '0;
    else begin
      if (rd_ok && bus_addr == OFS_STATUS) status <= {conv_eos, conv_eoc};
      else                                 status <= status | {conv_eos, conv_eoc};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (res_hit) rd_mux = 32'(res_rd);
    else begin
      case (bus_addr)
        OFS_STATUS: rd_mux = {30'b0, status};
        OFS_START:  rd_mux = {31'b0, start_reg};
        OFS_GIE:    rd_mux = {gie, 31'b0};
        OFS_ISR:    rd_mux = 32'(isr);
        OFS_IER:    rd_mux = 32'(ier);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  // R2: reads during a soft reset return zero
  a_r2_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (bus_rdata == 32'h0));
  // R7: an end-of-conversion pulse always leaves the status flag set
  a_r7_eoc_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_eoc && !sreset) |=> status[0]);
  // R4: no enabled pending bit means no interrupt next cycle
  a_r4_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ier) == '0) |=> !irq);
endmodule

// File: tb/adcmon_regif_test.sv
module adcmon_regif_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic conv_eoc = 1'b0, conv_eos = 1'b0, ext_start = 1'b0;
  logic [4:0] conv_chan = '0;
  logic [15:0] conv_data = '0;
  logic conv_start, conv_reset, irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] res_m [32];
  logic [7:0] isr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcmon_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .conv_eoc(conv_eoc), .conv_eos(conv_eos), .conv_chan(conv_chan),
    .conv_data(conv_data), .ext_start(ext_start), .conv_start(conv_start),
    .conv_reset(conv_reset), .irq(irq));

  function automatic logic [11:0] res_addr(input int ch);
    return 12'h200 + 12'(ch * 4);
  endfunction

  function automatic logic expect_irq(input logic g, input logic [7:0] s, input logic [7:0] e);
    return g & (|(s & e));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic conv(input logic [4:0] ch, input logic [15:0] d, input logic eos);
    @(negedge clk); conv_chan = ch; conv_data = d; conv_eoc = 1'b1; conv_eos = eos;
    @(negedge clk); conv_eoc = 1'b0; conv_eos = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hi;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) res_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state conv_reset", 32'(conv_reset), 0);
    check("R4 reset state irq", 32'(irq), 0);
    check("R8 reset state conv_start", 32'(conv_start), 0);

    // R10 unmapped reads zero
    bread(12'h0FC, rd); check("R10 unmapped", rd, 0);

    // R9 directed channel 3 at 0x20C
    conv(5'd3, 16'hBEEF, 1'b0); res_m[3] = 16'hBEEF;
    bread(12'h20C, rd); check("R9 channel 3", rd, 32'h0000_BEEF);

    // R7 status sticky and clear on read
    bread(12'h004, rd); check("R7 status before clear", rd, 32'h1);
    bread(12'h004, rd); check("R7 status after clear", rd, 32'h0);
    conv(5'd1, 16'h0001, 1'b1); res_m[1] = 16'h0001;
    bread(12'h004, rd); check("R7 eoc and eos", rd, 32'h3);

    // R5 toggle: ISR currently 0x03 from two conversions' flags
    isr_m = 8'h03;
    bwrite(12'h014, 32'h0000_003C); isr_m ^= 8'h3C;
    bread(12'h014, rd); check("R5 toggle set", rd, 32'(isr_m));
    bwrite(12'h014, rd); isr_m = 8'h00;
    bread(12'h014, rd); check("R5 write-back clears", rd, 0);

    // R3/R4 interrupt gating and timing
    bwrite(12'h018, 32'h0000_00FF);
    conv(5'd2, 16'h1234, 1'b0); res_m[2] = 16'h1234; isr_m = 8'h01;
    @(negedge clk);
    check("R3 gie off blocks irq", 32'(irq), 0);
    bwrite(12'h010, 32'h8000_0000);
    // write edge k: gie=1; irq updates at k+1
    check("R4 irq one cycle after enable", 32'(irq), 0);
    @(negedge clk);
    check("R4 irq raised", 32'(irq), 1);
    @(negedge clk); bus_addr = 12'h014; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; isr_m = 8'h00;
    check("R4 irq lags isr clear", 32'(irq), 1);
    @(negedge clk);
    check("R4 irq drops", 32'(irq), 0);
    bwrite(12'h018, 32'h0000_0002);
    conv(5'd4, 16'h0044, 1'b0); res_m[4] = 16'h0044; isr_m = 8'h01;
    @(negedge clk); @(negedge clk);
    check("R4 masked bit no irq", 32'(irq), 0);

    // R6 collision: hw set and toggle of bit 0 in same cycle (bit 0 is 1)
    @(negedge clk); bus_addr = 12'h014; bus_wdata = 32'h1; bus_wr = 1'b1;
    conv_eoc = 1'b1; conv_chan = 5'd5; conv_data = 16'h0555;
    @(negedge clk); bus_wr = 1'b0; conv_eoc = 1'b0; res_m[5] = 16'h0555;
    bread(12'h014, rd); check("R6 set wins over toggle", rd, 32'h1);
    bread(12'h004, rd);  // clear status

    // R7 collision: status read with eoc pulse in same cycle
    @(negedge clk); bus_addr = 12'h004; bus_rd = 1'b1;
    conv_eoc = 1'b1; conv_chan = 5'd6; conv_data = 16'h0666;
    @(negedge clk); bus_rd = 1'b0; conv_eoc = 1'b0; res_m[6] = 16'h0666;
    check("R7 colliding read sees old", bus_rdata, 0);
    bread(12'h004, rd); check("R7 set wins over read clear", rd, 32'h1);

    // R8 start sources
    bwrite(12'h008, 32'h1);
    check("R8 register start", 32'(conv_start), 1);
    bwrite(12'h008, 32'h0);
    check("R8 register cleared", 32'(conv_start), 0);
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk);
    check("R8 pin after one edge", 32'(conv_start), 0);
    @(negedge clk);
    check("R8 pin after two edges", 32'(conv_start), 1);
    ext_start = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 pin released", 32'(conv_start), 0);

    // R9 random conversions
    for (int i = 0; i < 40; i++) begin
      int ch;
      logic [15:0] d;
      ch = int'($urandom_range(31, 0));
      d = 16'($urandom());
      conv(5'(ch), d, 1'($urandom_range(1, 0)));
      res_m[ch] = d;
      bread(res_addr(int'($urandom_range(31, 0))), rd);
      check("R9 random result", rd, 32'(res_m[bus_addr[6:2]]));
    end

    // R5 random toggles against model
    bread(12'h014, rd); isr_m = rd[7:0];
    for (int i = 0; i < 10; i++) begin
      logic [7:0] t;
      t = 8'($urandom());
      bwrite(12'h014, 32'(t)); isr_m ^= t;
      bread(12'h014, rd); check("R5 random toggle", rd, 32'(isr_m));
    end
    bwrite(12'h010, 32'h8000_0000);
    bwrite(12'h018, 32'h0000_00FF);
    @(negedge clk);
    check("R4 model irq", 32'(irq), 32'(expect_irq(1'b1, isr_m, 8'hFF)));

    // R1 wrong key ignored
    bwrite(12'h000, 32'h0000_000B);
    check("R1 wrong key no reset", 32'(conv_reset), 0);
    bread(12'h018, rd); check("R1 wrong key keeps IER", rd, 32'hFF);

    // R1/R2 keyed reset
    bwrite(12'h008, 32'h1);
    @(negedge clk); bus_addr = 12'h000; bus_wdata = 32'h0000_000A; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    hi = 0;
    bus_addr = 12'h018; bus_rd = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (conv_reset) begin
        hi++;
        if (i > 0) check("R2 read zero during reset", bus_rdata, 0);
      end
      @(negedge clk);
    end
    bus_rd = 1'b0;
    check("R1 reset length", 32'(hi), 16);
    bread(12'h018, rd); check("R2 IER cleared", rd, 0);
    bread(12'h010, rd); check("R2 GIE cleared", rd, 0);
    bread(12'h014, rd); check("R2 ISR cleared", rd, 0);
    bread(12'h20C, rd); check("R2 result cleared", rd, 0);
    check("R2 start cleared", 32'(conv_start), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule